// File: doc/BRIEF.md
# Rotating Segment Direction Indicator

This block drives one common-cathode seven-segment digit so that a single lit segment appears to travel around the outer ring of the digit. One input picks the direction of travel. A second input halts the travel and replaces the ring position with a dedicated halt symbol.

The machine moves one step for each pulse of a slow step enable, nominally 5 Hz, which is generated outside the block. The direction and halt inputs are sampled only on clock edges where the enable is high. Each segment output is high when its segment should light.

Segment bit positions are fixed: `seg_o[0]` is a, `seg_o[1]` is b, through `seg_o[5]` for f, and `seg_o[6]` is the middle segment g.

Top module: `rot_indicator`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `seg_o` is 7'b0000001 (segment a only). The state is cleared asynchronously.
- R2: On a clock edge with `step_i` low, `seg_o` keeps its value.
- R3: On a step with `stop_i`=0 and `up_i`=1, the lit segment moves forward a→b→c→d→e→f. After f it wraps to a.
- R4: On a step with `stop_i`=0 and `up_i`=0, the lit segment moves backward f→e→d→c→b→a. After a it wraps to f.
- R5: On a step with `stop_i`=1, `seg_o` becomes 7'b1000000 (segment g only), whatever the value of `up_i`. The ring position is held.
- R6: On the first step with `stop_i`=0 after a halt, travel resumes from the held position, one step in the direction selected by `up_i`.
- R7: Exactly one bit of `seg_o` is high at all times.
- R8: Changes on `up_i` and `stop_i` while `step_i` is low have no effect on `seg_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Single-cycle step enable (slow rate) |
| up_i | input | 1 | 1 selects forward travel, 0 selects backward travel |
| stop_i | input | 1 | 1 halts travel and shows the halt symbol; overrides `up_i` |
| seg_o | output | 7 | Active-high segment drives, bit 0 = a through bit 6 = g |

## Verification
The state register sits one flop away from the inputs, and `seg_o` is decoded from it with no further register. Every result therefore appears on `seg_o` in the cycle right after the clock edge that sampled the step.

The driver presents the inputs at a falling edge and pushes the expected pattern after the next rising edge. The monitor compares that pattern at the following falling edge, exactly one cycle after the stimulus.

Idle cycles with toggled direction and halt inputs push the unchanged pattern, so any change that should not happen is seen in that same slot.

// File: rtl/rot_pkg.sv
package rot_pkg;
  parameter int unsigned NUM_POS = 6;
  parameter int unsigned SEG_W   = 7;
  localparam int unsigned POS_W  = $clog2(NUM_POS);

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/rot_step_ctrl.sv
module rot_step_ctrl #(
  parameter int unsigned NUM_POS = rot_pkg::NUM_POS,
  localparam int unsigned POS_W  = $clog2(NUM_POS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             stop_i,
  output logic [POS_W-1:0] pos_o,
  output logic             halt_o
);
  import rot_pkg::*;

  localparam logic [POS_W-1:0] LAST = POS_W'(NUM_POS - 1);

  dir_e             dir;
  logic [POS_W-1:0] pos_fwd, pos_bwd, pos_d;
  logic             halt_d;

  assign dir     = up_i ? DIR_UP : DIR_DOWN;
  assign pos_fwd = (pos_o == LAST) ? '0 : pos_o + 1'b1;
  assign pos_bwd = (pos_o == '0) ? LAST : pos_o - 1'b1;

  always_comb begin
    pos_d  = pos_o;
    halt_d = halt_o;
    if (step_i) begin
      if (stop_i) begin
        halt_d = 1'b1;  // halt wins over direction
      end else begin
        halt_d = 1'b0;
        pos_d  = (dir == DIR_UP) ? pos_fwd : pos_bwd;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      halt_o <= 1'b0;
    end else begin
      pos_o  <= pos_d;
      halt_o <= halt_d;
    end
  end

  p_fwd_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !stop_i && up_i && (pos_o == LAST) |=> pos_o == '0);

  p_bwd_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !stop_i && !up_i && (pos_o == '0) |=> pos_o == LAST);

  p_halt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && stop_i |=> halt_o && $stable(pos_o));

  p_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && step_i && !stop_i |=> !halt_o && !$stable(pos_o));

  p_pos_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= LAST);
endmodule

// File: rtl/rot_seg_enc.sv
module rot_seg_enc #(
  parameter int unsigned NUM_POS = rot_pkg::NUM_POS,
  parameter int unsigned SEG_W   = rot_pkg::SEG_W,
  localparam int unsigned POS_W  = $clog2(NUM_POS)
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             halt_i,
  output logic [SEG_W-1:0] seg_o
);
  // ring segments occupy the low bits, halt symbol uses the top bit
  for (genvar i = 0; i < SEG_W - 1; i++) begin : g_ring
    if (i < NUM_POS) begin : g_used
      assign seg_o[i] = !halt_i && (pos_i == POS_W'(i));
    end else begin : g_unused
      assign seg_o[i] = 1'b0;
    end
  end

  assign seg_o[SEG_W-1] = halt_i;
endmodule

// File: rtl/rot_indicator.sv
module rot_indicator #(
  parameter int unsigned NUM_POS = rot_pkg::NUM_POS,
  parameter int unsigned SEG_W   = rot_pkg::SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             stop_i,
  output logic [SEG_W-1:0] seg_o
);
  localparam int unsigned POS_W = $clog2(NUM_POS);

  logic [POS_W-1:0] pos;
  logic             halt;

  rot_step_ctrl #(.NUM_POS(NUM_POS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .up_i   (up_i),
    .stop_i (stop_i),
    .pos_o  (pos),
    .halt_o (halt)
  );

  rot_seg_enc #(.NUM_POS(NUM_POS), .SEG_W(SEG_W)) u_enc (
    .pos_i  (pos),
    .halt_i (halt),
    .seg_o  (seg_o)
  );

  p_one_lit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(seg_o));

  // R2 and R8: nothing moves without a step
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(seg_o));

  p_halt_sym_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && stop_i |=> seg_o == SEG_W'(1) << (SEG_W - 1));
endmodule

// File: tb/sim_rot_indicator.sv
module sim_rot_indicator;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic       up_i = 1'b1;
  logic       stop_i = 1'b0;
  logic [6:0] seg_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  int m_pos = 0;
  bit m_halt = 1'b0;

  always #5 clk = ~clk;

  rot_indicator u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .up_i   (up_i),
    .stop_i (stop_i),
    .seg_o  (seg_o)
  );

  function automatic logic [6:0] model_seg();
    return m_halt ? 7'b1000000 : 7'(1 << m_pos);
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: seg_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the monitor
  task automatic drive(bit stp, bit up, bit hlt, string tag);
    @(negedge clk);
    step_i = stp;
    up_i   = up;
    stop_i = hlt;
    @(posedge clk);
    if (stp) begin
      if (hlt) m_halt = 1'b1;
      else begin
        m_halt = 1'b0;
        m_pos  = up ? (m_pos + 1) % 6 : (m_pos + 5) % 6;
      end
    end
    exp_q.push_back(model_seg());
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, seg_o, e);
      total++;
      if ($countones(seg_o) != 1) begin
        bad++;
        $display("FAIL R7: ones=%0d expected=1", $countones(seg_o));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        bad++;
        $display("FAIL watchdog: cycles=%0d expected<=5000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    #1;
    check("R1", seg_o, 7'b0000001);  // during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", seg_o, 7'b0000001);

    // R3: forward through all six and wrap
    for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 1'b0, "R3");

    // R2 / R8: inputs wiggle without a step
    drive(1'b0, 1'b0, 1'b0, "R2");
    drive(1'b0, 1'b1, 1'b1, "R8");
    drive(1'b0, 1'b0, 1'b1, "R8");

    // R4: backward through a, wrap to f, onward
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 1'b0, "R4");

    // R5: halt with either direction
    drive(1'b1, 1'b1, 1'b1, "R5");
    drive(1'b1, 1'b0, 1'b1, "R5");
    drive(1'b0, 1'b1, 1'b0, "R8");
    // R6: resume forward from held position
    drive(1'b1, 1'b1, 1'b0, "R6");
    drive(1'b1, 1'b1, 1'b1, "R5");
    // R6: resume backward
    drive(1'b1, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, 1'b0, "R4");

    // R1: asynchronous reset mid-run
    drive(1'b1, 1'b1, 1'b0, "R3");
    @(negedge clk);
    @(negedge clk);
    step_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check("R1", seg_o, 7'b0000001);
    m_pos = 0;
    m_halt = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b1, 1'b1, 1'b0, "R3");
    drive(1'b1, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b0, 1'b0, "R4");

    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule